// File: doc/BRIEF.md
# Priority-Masked Interrupt Acceptance Unit

This block decides, at each instruction boundary, whether one pending maskable interrupt is taken. It holds a pending bit and a 3-bit priority level for each source, plus a global enable flag and a processor priority level. When a boundary strobe arrives, the block compares every pending source against the processor level and picks the winner. If the effective enable is set, it accepts that source, reports it on a single-cycle accept pulse and clears its pending bit. In the same step it masks further interrupts by clearing the enable flag and raising the processor level to the level of the accepted source.

The enable flag has two update paths with different timing. An ordinary flag write takes effect late: the acceptance check at the first boundary at or after the write still sees the old value, and only later boundaries see the new one. A return-from-interrupt update takes effect at once: a boundary in the same cycle already sees the new value. Software can clear pending bits but can never set them.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset the enable flag is 0, the processor level is 0, all pending bits and source levels are 0, and no accept pulse is given.
- R2: A high `src_raise[i]` sets pending bit i in the next cycle. Acceptance clears the accepted source's bit. A raise in the same cycle as a clear of the same bit wins.
- R3: A software write (`sw_req_we`) with `sw_req_val`=0 clears pending bit `sw_req_idx`. A write with value 1 leaves the bit unchanged.
- R4: A source is accepted only when all of these hold in the same cycle: `boundary` is 1, the effective enable is 1, its pending bit is 1, and its level is strictly greater than the processor level. A source at level 0 is never accepted. Levels are written through `lvl_we`/`lvl_idx`/`lvl_val` and apply from the next cycle.
- R5: Among qualifying sources, the one with the highest level wins. Ties go to the lowest source index.
- R6: An acceptance at a boundary in cycle c produces `acc_valid`=1 in cycle c+1 for exactly one cycle, with `acc_idx` and `acc_lvl` giving the winner. At most one source is accepted per boundary.
- R7: On acceptance the enable flag is cleared and the processor level is loaded with the winner's level. This overrides any flag, return or level write in the same cycle.
- R8: An ordinary flag write (`flag_we`, `flag_val`) appears on `ien_o` in the next cycle. The acceptance check at the first boundary at or after the write uses the previous value. Later boundaries use the new value.
- R9: A return-from-interrupt update (`reit_we`, `reit_val`) is used by a boundary check in the same cycle and appears on `ien_o` in the next cycle. It wins over an ordinary flag write in the same cycle.
- R10: A processor level write (`ipl_we`, `ipl_val`) appears on `ipl_o` in the next cycle. A boundary in the same cycle still compares against the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_raise | input | NSRC | Per-source hardware interrupt request |
| sw_req_we | input | 1 | Software write to one pending bit |
| sw_req_idx | input | IDX_W | Pending bit selected by the software write |
| sw_req_val | input | 1 | Value written (0 clears, 1 ignored) |
| lvl_we | input | 1 | Write a source priority level |
| lvl_idx | input | IDX_W | Source whose level is written |
| lvl_val | input | 3 | New level for that source |
| flag_we | input | 1 | Ordinary (delayed) enable flag write |
| flag_val | input | 1 | Value for the ordinary write |
| reit_we | input | 1 | Return-from-interrupt enable update |
| reit_val | input | 1 | Value restored by the return |
| ipl_we | input | 1 | Processor priority level write |
| ipl_val | input | 3 | New processor priority level |
| boundary | input | 1 | Instruction-boundary strobe |
| acc_valid | output | 1 | Single-cycle accept pulse |
| acc_idx | output | IDX_W | Accepted source index |
| acc_lvl | output | 3 | Accepted source level |
| ien_o | output | 1 | Architectural enable flag |
| ipl_o | output | 3 | Processor priority level |
| req_o | output | NSRC | Pending request bits |

## Verification
The hardest case is telling the two enable timings apart. This only shows at a boundary that lands on, or follows, a flag change while pending sources sit above the processor level. The bench therefore arms sources first, then issues an ordinary write together with a boundary and checks that nothing is accepted before the following boundary. It also pairs a return update with a boundary in the same cycle and expects an immediate accept. A long random phase then mixes boundaries, both update paths, level writes and racing raise/clear pairs. A behavioural model compares every cycle, which catches rarer overlaps such as an acceptance that discards a pending ordinary write.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank
  import irq_accept_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       raise,
  input  logic                  sw_we,
  input  logic [IDX_W-1:0]      sw_idx,
  input  logic                  sw_val,
  input  logic                  lvl_we,
  input  logic [IDX_W-1:0]      lvl_idx,
  input  lvl_t                  lvl_val,
  input  logic                  acc_go,
  input  logic [IDX_W-1:0]      acc_idx,
  output logic [NSRC-1:0]       req_q,
  output lvl_t [NSRC-1:0]       lvl_q
);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic pend_q, pend_n, pend_en;
    lvl_t prio_q;
    logic prio_en;

    // next-state for this source's pending bit
    always_comb begin
      pend_n = pend_q;
      if (sw_we && (sw_idx == IDX_W'(i)) && !sw_val) pend_n = 1'b0;
      if (acc_go && (acc_idx == IDX_W'(i)))          pend_n = 1'b0;
      if (raise[i])                                  pend_n = 1'b1;
    end

    assign pend_en = raise[i] | sw_we | acc_go;
    assign prio_en = lvl_we && (lvl_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (pend_en) pend_q <= pend_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prio_q <= '0;
      else if (prio_en) prio_q <= lvl_val;
    end

    assign req_q[i] = pend_q;
    assign lvl_q[i] = prio_q;
  end

  // R2: every raised source is pending in the next cycle
  assert_raise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|raise) |=> ((req_q & $past(raise)) == $past(raise)));

  // R3: a software write of 1 never sets a bit
  assert_sw_one_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && sw_val && !acc_go && !raise[sw_idx]) |=>
      (req_q[$past(sw_idx)] == $past(req_q[sw_idx])));

endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_accept_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  req,
  input  lvl_t [NSRC-1:0]  lvl,
  input  lvl_t             ipl,
  output logic             found,
  output logic [IDX_W-1:0] win_idx,
  output lvl_t             win_lvl
);

  logic [NSRC-1:0] qual;

  for (genvar i = 0; i < NSRC; i++) begin : g_qual
    assign qual[i] = req[i] && (lvl[i] > ipl);
  end

  // scan from the top index down; >= lets the lower index take a tie
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (qual[i] && (!found || (lvl[i] >= win_lvl))) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvl[i];
      end
    end
  end

  always_comb begin
    if (found) begin
      assert_win_qualified_R4: assert (qual[win_idx]);
    end
    for (int i = 0; i < NSRC; i++) begin
      if (found && qual[i]) begin
        assert_win_highest_R5: assert (lvl[i] <= win_lvl);
        if (lvl[i] == win_lvl) begin
          assert_win_lowest_idx_R5: assert (IDX_W'(i) >= win_idx);
        end
      end
    end
  end

endmodule

// File: rtl/irq_flag_ctl.sv
module irq_flag_ctl
  import irq_accept_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic boundary,
  input  logic flag_we,
  input  logic flag_val,
  input  logic reit_we,
  input  logic reit_val,
  input  logic ipl_we,
  input  lvl_t ipl_val,
  input  logic acc_go,
  input  lvl_t acc_lvl,
  output logic ien_q,
  output lvl_t ipl_q,
  output logic chk_en
);

  logic eff_q;
  logic ien_n, eff_n;
  lvl_t ipl_n;
  logic upd_en;

  // enable used by the check: a return update acts at once
  assign chk_en = reit_we ? reit_val : eff_q;

  always_comb begin
    ien_n = ien_q;
    eff_n = eff_q;
    ipl_n = ipl_q;
    if (ipl_we)  ipl_n = ipl_val;
    if (flag_we) ien_n = flag_val;
    if (reit_we) begin
      ien_n = reit_val;
      eff_n = reit_val;
    end
    // a delayed write becomes effective once this boundary is past
    if (boundary) eff_n = ien_n;
    if (acc_go) begin
      ien_n = 1'b0;
      eff_n = 1'b0;
      ipl_n = acc_lvl;
    end
  end

  assign upd_en = ipl_we | flag_we | reit_we | boundary | acc_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0;
      eff_q <= 1'b0;
      ipl_q <= '0;
    end else if (upd_en) begin
      ien_q <= ien_n;
      eff_q <= eff_n;
      ipl_q <= ipl_n;
    end
  end

  assert_accept_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go |=> (!ien_q && (ipl_q == $past(acc_lvl))));

  assert_reit_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reit_we && !acc_go) |=> (ien_q == $past(reit_val)));

  assert_plain_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !reit_we && !acc_go) |=> (ien_q == $past(flag_val)));

  assert_ipl_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl_we && !acc_go) |=> (ipl_q == $past(ipl_val)));

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      src_raise,
  input  logic                 sw_req_we,
  input  logic [IDX_W-1:0]     sw_req_idx,
  input  logic                 sw_req_val,
  input  logic                 lvl_we,
  input  logic [IDX_W-1:0]     lvl_idx,
  input  logic [LVL_W-1:0]     lvl_val,
  input  logic                 flag_we,
  input  logic                 flag_val,
  input  logic                 reit_we,
  input  logic                 reit_val,
  input  logic                 ipl_we,
  input  logic [LVL_W-1:0]     ipl_val,
  input  logic                 boundary,
  output logic                 acc_valid,
  output logic [IDX_W-1:0]     acc_idx,
  output logic [LVL_W-1:0]     acc_lvl,
  output logic                 ien_o,
  output logic [LVL_W-1:0]     ipl_o,
  output logic [NSRC-1:0]      req_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NSRC-1:0]  req_q;
  lvl_t [NSRC-1:0]  lvl_q;
  logic             found;
  logic [IDX_W-1:0] win_idx;
  lvl_t             win_lvl;
  lvl_t             ipl_q;
  logic             ien_q;
  logic             chk_en;
  logic             acc_go;

  assign acc_go = boundary && chk_en && found;

  irq_req_bank #(.NSRC(NSRC), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .raise   (src_raise),
    .sw_we   (sw_req_we),
    .sw_idx  (sw_req_idx),
    .sw_val  (sw_req_val),
    .lvl_we  (lvl_we),
    .lvl_idx (lvl_idx),
    .lvl_val (lvl_val),
    .acc_go  (acc_go),
    .acc_idx (win_idx),
    .req_q   (req_q),
    .lvl_q   (lvl_q)
  );

  irq_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
    .req     (req_q),
    .lvl     (lvl_q),
    .ipl     (ipl_q),
    .found   (found),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  irq_flag_ctl u_flag (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .boundary (boundary),
    .flag_we  (flag_we),
    .flag_val (flag_val),
    .reit_we  (reit_we),
    .reit_val (reit_val),
    .ipl_we   (ipl_we),
    .ipl_val  (ipl_val),
    .acc_go   (acc_go),
    .acc_lvl  (win_lvl),
    .ien_q    (ien_q),
    .ipl_q    (ipl_q),
    .chk_en   (chk_en)
  );

  // accept report registers
  logic             av_q;
  logic [IDX_W-1:0] ai_q;
  lvl_t             al_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) av_q <= 1'b0;
    else            av_q <= acc_go;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ai_q <= '0;
      al_q <= '0;
    end else if (acc_go) begin
      ai_q <= win_idx;
      al_q <= win_lvl;
    end
  end

  assign acc_valid = av_q;
  assign acc_idx   = ai_q;
  assign acc_lvl   = al_q;
  assign ien_o     = ien_q;
  assign ipl_o     = ipl_q;
  assign req_o     = req_q;

  assert_pulse_from_boundary_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_valid |-> $past(boundary));

  assert_level_above_ipl_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc_go |-> (win_lvl > ipl_q) && req_q[win_idx]);

  assert_accept_clears_req_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_go && !src_raise[win_idx]) |=> !req_o[$past(win_idx)]);

endmodule

// File: tb/tb_irq_accept_unit.sv
module tb_irq_accept_unit;
  localparam int CLK_P = 10;
  localparam int NSRC  = 8;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NSRC-1:0]  src_raise = '0;
  logic             sw_req_we = 1'b0;
  logic [IDX_W-1:0] sw_req_idx = '0;
  logic             sw_req_val = 1'b0;
  logic             lvl_we = 1'b0;
  logic [IDX_W-1:0] lvl_idx = '0;
  logic [2:0]       lvl_val = '0;
  logic             flag_we = 1'b0;
  logic             flag_val = 1'b0;
  logic             reit_we = 1'b0;
  logic             reit_val = 1'b0;
  logic             ipl_we = 1'b0;
  logic [2:0]       ipl_val = '0;
  logic             boundary = 1'b0;
  logic             acc_valid;
  logic [IDX_W-1:0] acc_idx;
  logic [2:0]       acc_lvl;
  logic             ien_o;
  logic [2:0]       ipl_o;
  logic [NSRC-1:0]  req_o;

  always #(CLK_P/2) clk = ~clk;

  irq_accept_unit #(.NSRC(NSRC), .IDX_W(IDX_W)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_req[NSRC];
  int m_lvl[NSRC];
  bit m_ien, m_eff;
  int m_ipl;
  bit m_av;
  int m_ai, m_al;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_req[i]) begin m_req[i] = 0; m_lvl[i] = 0; end
      m_ien = 0; m_eff = 0; m_ipl = 0; m_av = 0; m_ai = 0; m_al = 0;
    end else begin
      bit en_now;
      int best;
      bit go;
      en_now = reit_we ? reit_val : m_eff;
      best = -1;
      for (int i = 0; i < NSRC; i++)
        if (m_req[i] && m_lvl[i] > m_ipl && (best < 0 || m_lvl[i] > m_lvl[best])) best = i;
      go = boundary && en_now && (best >= 0);
      m_av = go;
      if (go) begin m_ai = best; m_al = m_lvl[best]; end
      if (sw_req_we && !sw_req_val) m_req[sw_req_idx] = 0;
      if (go) m_req[best] = 0;
      for (int i = 0; i < NSRC; i++) if (src_raise[i]) m_req[i] = 1;
      if (lvl_we) m_lvl[lvl_idx] = lvl_val;
      if (ipl_we) m_ipl = ipl_val;
      if (flag_we) m_ien = flag_val;
      if (reit_we) begin m_ien = reit_val; m_eff = reit_val; end
      if (boundary) m_eff = m_ien;
      if (go) begin m_ien = 0; m_eff = 0; m_ipl = m_al; end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      int mreq;
      mreq = 0;
      for (int i = 0; i < NSRC; i++) if (m_req[i]) mreq |= (1 << i);
      chk(acc_valid == m_av, "R6 acc_valid", acc_valid, m_av);
      if (m_av) begin
        chk(int'(acc_idx) == m_ai, "R5 acc_idx", acc_idx, m_ai);
        chk(int'(acc_lvl) == m_al, "R6 acc_lvl", acc_lvl, m_al);
      end
      chk(int'(req_o) == mreq, "R2 req_o", req_o, mreq);
      chk(ien_o == m_ien, "R8 ien_o", ien_o, m_ien);
      chk(int'(ipl_o) == m_ipl, "R7 ipl_o", ipl_o, m_ipl);
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    src_raise = '0; sw_req_we = 0; lvl_we = 0; flag_we = 0;
    reit_we = 0; ipl_we = 0; boundary = 0;
  endtask

  task automatic set_lvl(input int idx, input int v);
    lvl_we = 1; lvl_idx = IDX_W'(idx); lvl_val = 3'(v);
    tick();
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    checks++;
    $display("FAIL R6 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(ien_o == 0 && ipl_o == 0 && req_o == 0 && acc_valid == 0, "R1 reset", {ien_o, ipl_o, req_o}, 0);
    cmp_on = 1;

    set_lvl(2, 5); set_lvl(5, 5); set_lvl(1, 3); set_lvl(7, 0);
    src_raise = 8'b1010_0110; tick();
    chk(req_o == 8'b1010_0110, "R2 raise", req_o, 8'b1010_0110);

    boundary = 1; tick();
    chk(acc_valid == 0, "R4 disabled", acc_valid, 0);

    // R8: ordinary write with boundary in same cycle -> old value used
    flag_we = 1; flag_val = 1; boundary = 1; tick();
    chk(acc_valid == 0, "R8 old value at boundary", acc_valid, 0);
    chk(ien_o == 1, "R8 flag visible", ien_o, 1);
    boundary = 1; tick();
    chk(acc_valid == 1 && acc_idx == 2 && acc_lvl == 5, "R5 tie lowest index", acc_idx, 2);
    chk(ien_o == 0 && ipl_o == 5, "R7 mask on accept", {ien_o, ipl_o}, 5);
    chk(req_o[2] == 0, "R2 cleared on accept", req_o[2], 0);

    // R9: return update same cycle, but level 5 not above ipl 5
    reit_we = 1; reit_val = 1; boundary = 1; tick();
    chk(acc_valid == 0, "R4 level not above ipl", acc_valid, 0);
    chk(ien_o == 1, "R9 return lands", ien_o, 1);
    // R10: ipl write with boundary uses old ipl
    ipl_we = 1; ipl_val = 0; boundary = 1; tick();
    chk(acc_valid == 0 && ipl_o == 0, "R10 old ipl at boundary", acc_valid, 0);
    boundary = 1; tick();
    chk(acc_valid == 1 && acc_idx == 5, "R6 accept after ipl drop", acc_idx, 5);

    // R9: immediate acceptance on return update
    ipl_we = 1; ipl_val = 0; tick();
    reit_we = 1; reit_val = 1; boundary = 1; tick();
    chk(acc_valid == 1 && acc_idx == 1 && acc_lvl == 3, "R9 return acts at once", acc_idx, 1);

    // R4: level 0 never accepted
    ipl_we = 1; ipl_val = 0; tick();
    reit_we = 1; reit_val = 1; boundary = 1; tick();
    chk(acc_valid == 0 && req_o[7] == 1, "R4 level zero masked", acc_valid, 0);

    // R3: software write of 1 ignored, 0 clears
    sw_req_we = 1; sw_req_idx = 7; sw_req_val = 1; tick();
    chk(req_o[7] == 1, "R3 write one ignored", req_o[7], 1);
    sw_req_we = 1; sw_req_idx = 7; sw_req_val = 0; tick();
    chk(req_o[7] == 0, "R3 write zero clears", req_o[7], 0);

    // random mixed traffic, compared against the model each cycle
    for (int n = 0; n < 4000; n++) begin
      boundary = ($urandom % 3) == 0;
      for (int i = 0; i < NSRC; i++) src_raise[i] = ($urandom % 16) == 0;
      if ($urandom % 12 == 0) begin flag_we = 1; flag_val = 1'($urandom); end
      if ($urandom % 16 == 0) begin reit_we = 1; reit_val = 1'($urandom); end
      if ($urandom % 20 == 0) begin ipl_we = 1; ipl_val = 3'($urandom); end
      if ($urandom % 10 == 0) begin lvl_we = 1; lvl_idx = 3'($urandom); lvl_val = 3'($urandom); end
      if ($urandom % 10 == 0) begin sw_req_we = 1; sw_req_idx = 3'($urandom); sw_req_val = 1'($urandom); end
      tick();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule